// File: doc/BRIEF.md
# Single-Cycle Integer Execute Stage

This block runs one 32-bit integer instruction per clock from a small fixed-width subset. Each cycle in which the enable input is high, the instruction word is decoded, two source registers are read from a 32 × 32-bit register file, and the result is written back into that register file on the rising edge. The supported operations are add, subtract-unsigned, shift-left-logical, add-immediate, signed and unsigned set-less-than with an immediate, OR with an immediate, and load-upper-immediate.

Register-format words carry an opcode of 0, and a 6-bit function field picks the operation. These words write the rd field. Immediate-format words pick the operation with the opcode alone and write the rt field. How the 16-bit immediate is widened depends on the operation.

Any word that is not in the subset writes nothing and raises a one-cycle illegal flag. A separate read port lets a test environment inspect any register at any time. Register 0 is a constant zero.

Top module: `int_exec_core`

## Requirements
- R1: While reset is asserted and right after it is released, every register reads 0 through the debug port and `illegal` is 0.
- R2: With opcode 0 (bits 31:26) and function 32 (bits 5:0), rd (bits 15:11) receives rs (bits 25:21) plus rt (bits 20:16), taken modulo 2^32 with no trap. For example, word 0x012A4020 writes r9+r10 into r8.
- R3: With opcode 0 and function 35, rd receives rs minus rt, taken modulo 2^32.
- R4: With opcode 0 and function 0, rd receives rt shifted left by shamt (bits 10:6), for shift counts 0 to 31. Instructions that do not shift ignore shamt.
- R5: Opcode 8 writes rs plus the sign-extended 16-bit immediate (bits 15:0) into rt. For example, word 0x22D5FFCE writes r22−50 into r21.
- R6: Opcode 10 writes 1 into rt when rs is less than the sign-extended immediate under a signed comparison, and writes 0 otherwise.
- R7: Opcode 11 writes 1 into rt when rs is less than the sign-extended immediate under an unsigned comparison, and writes 0 otherwise.
- R8: Opcode 13 writes rs OR the zero-extended immediate into rt.
- R9: Opcode 15 writes the immediate into bits 31:16 of rt and clears bits 15:0.
- R10: Register 0 always reads 0, and a write aimed at it is discarded.
- R11: Any other opcode, or opcode 0 with a function code other than 0, 32 or 35, writes no register. It sets `illegal` high during the cycle after its execute edge, for that one cycle only.
- R12: When `insn_en` is low, no register is written and `illegal` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_en | input | 1 | Execute the word on `insn` at this edge |
| insn | input | 32 | Instruction word |
| dbg_sel | input | 5 | Register index for the debug read port |
| dbg_data | output | 32 | Content of register `dbg_sel` (combinational) |
| illegal | output | 1 | Registered pulse for an unsupported word |

## Verification
The assertions check on every cycle that register 0 reads zero and that the `illegal` pulse matches an independent legality decode of the previous word. They also check that register contents hold still after a disabled or illegal cycle, and that load-upper-immediate places its immediate correctly. The arithmetic results of the directed scenarios can only be shown by the bench, because they depend on values loaded earlier: the wrap of add and subtract, shift counts at 0 and 31, signed against unsigned comparisons near the sign boundary, and sign extension against zero extension.

// File: rtl/exec_pkg.sv
package exec_pkg;

   localparam int FIELD_AW = 5;

   localparam logic [5:0] OPC_RTYPE = 6'd0;
   localparam logic [5:0] OPC_ADDI  = 6'd8;
   localparam logic [5:0] OPC_SLTI  = 6'd10;
   localparam logic [5:0] OPC_SLTIU = 6'd11;
   localparam logic [5:0] OPC_ORI   = 6'd13;
   localparam logic [5:0] OPC_LUI   = 6'd15;

   localparam logic [5:0] FN_SLL  = 6'd0;
   localparam logic [5:0] FN_ADD  = 6'd32;
   localparam logic [5:0] FN_SUBU = 6'd35;

   typedef enum logic [3:0] {
      XOP_NONE,
      XOP_ADD,
      XOP_SUBU,
      XOP_SLL,
      XOP_ADDI,
      XOP_SLTI,
      XOP_SLTIU,
      XOP_ORI,
      XOP_LUI
   } xop_e;

   typedef struct packed {
      xop_e                op;
      logic                legal;
      logic [FIELD_AW-1:0] src_a;
      logic [FIELD_AW-1:0] src_b;
      logic [FIELD_AW-1:0] dst;
      logic [FIELD_AW-1:0] shamt;
      logic [15:0]         imm;
   } xdec_t;

endpackage

// File: rtl/exec_decode.sv
module exec_decode
   import exec_pkg::*;
(
   input  logic [31:0] word,
   output xdec_t       dec
);

   logic [5:0] opc;
   logic [5:0] fn;

   assign opc = word[31:26];
   assign fn  = word[5:0];

   always_comb begin
      dec.src_a = word[25:21];
      dec.src_b = word[20:16];
      dec.shamt = word[10:6];
      dec.imm   = word[15:0];
      dec.dst   = word[20:16];
      dec.op    = XOP_NONE;
      dec.legal = 1'b1;
      unique case (opc)
         OPC_RTYPE: begin
            dec.dst = word[15:11];
            unique case (fn)
               FN_ADD:  dec.op = XOP_ADD;
               FN_SUBU: dec.op = XOP_SUBU;
               FN_SLL:  dec.op = XOP_SLL;
               default: dec.legal = 1'b0;
            endcase
         end
         OPC_ADDI:  dec.op = XOP_ADDI;
         OPC_SLTI:  dec.op = XOP_SLTI;
         OPC_SLTIU: dec.op = XOP_SLTIU;
         OPC_ORI:   dec.op = XOP_ORI;
         OPC_LUI:   dec.op = XOP_LUI;
         default:   dec.legal = 1'b0;
      endcase
   end

endmodule

// File: rtl/exec_alu.sv
module exec_alu
   import exec_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter bit LOG_SHIFTER = 1'b1
) (
   input  xop_e                op,
   input  logic [DATA_W-1:0]   opa,
   input  logic [DATA_W-1:0]   opb,
   input  logic [FIELD_AW-1:0] shamt,
   input  logic [15:0]         imm,
   output logic [DATA_W-1:0]   res
);

   localparam int EXT_W = DATA_W - 16;

   logic [DATA_W-1:0] imm_sx;
   logic [DATA_W-1:0] imm_zx;
   logic [DATA_W-1:0] shl;

   assign imm_sx = {{EXT_W{imm[15]}}, imm};
   assign imm_zx = {{EXT_W{1'b0}}, imm};

   generate
      if (LOG_SHIFTER) begin : g_log_shift
         logic [DATA_W-1:0] stage [FIELD_AW+1];
         assign stage[0] = opb;
         for (genvar s = 0; s < FIELD_AW; s++) begin : g_stage
            assign stage[s+1] = shamt[s] ? (stage[s] << (1 << s)) : stage[s];
         end
         assign shl = stage[FIELD_AW];
      end else begin : g_op_shift
         assign shl = opb << shamt;
      end
   endgenerate

   always_comb begin
      res = '0;
      unique case (op)
         XOP_ADD:   res = opa + opb;
         XOP_SUBU:  res = opa - opb;
         XOP_SLL:   res = shl;
         XOP_ADDI:  res = opa + imm_sx;
         XOP_SLTI:  res = {{(DATA_W-1){1'b0}}, ($signed(opa) < $signed(imm_sx))};
         XOP_SLTIU: res = {{(DATA_W-1){1'b0}}, (opa < imm_sx)};
         XOP_ORI:   res = opa | imm_zx;
         XOP_LUI:   res = {imm, {EXT_W{1'b0}}};
         default:   res = '0;
      endcase
   end

endmodule

// File: rtl/exec_regfile.sv
module exec_regfile
   import exec_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [FIELD_AW-1:0] waddr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [FIELD_AW-1:0] ra_a,
   input  logic [FIELD_AW-1:0] ra_b,
   input  logic [FIELD_AW-1:0] ra_dbg,
   output logic [DATA_W-1:0]   rd_a,
   output logic [DATA_W-1:0]   rd_b,
   output logic [DATA_W-1:0]   rd_dbg
);

   localparam int FLAT_W = NUM_REGS * DATA_W;

   logic [FLAT_W-1:0] flat;

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
         if (g == 0) begin : g_zero
            assign flat[DATA_W-1:0] = '0;
         end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q <= '0;
               else if (we && (waddr == FIELD_AW'(g)))
                  q <= wdata;
            end
            assign flat[g*DATA_W +: DATA_W] = q;
         end
      end
   endgenerate

   assign rd_a   = flat[ra_a   * DATA_W +: DATA_W];
   assign rd_b   = flat[ra_b   * DATA_W +: DATA_W];
   assign rd_dbg = flat[ra_dbg * DATA_W +: DATA_W];

endmodule

// File: rtl/int_exec_core.sv
module int_exec_core
   import exec_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int NUM_REGS    = 32,
   parameter bit LOG_SHIFTER = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                insn_en,
   input  logic [31:0]         insn,
   input  logic [4:0]          dbg_sel,
   output logic [DATA_W-1:0]   dbg_data,
   output logic                illegal
);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("int_exec_core: DATA_W must be 32");
      end
      if (NUM_REGS != (1 << FIELD_AW)) begin : g_bad_depth
         $error("int_exec_core: NUM_REGS must match the 5-bit register fields");
      end
   endgenerate

   xdec_t             dec;
   logic [DATA_W-1:0] val_a;
   logic [DATA_W-1:0] val_b;
   logic [DATA_W-1:0] result;
   logic              wr_en;
   logic              illegal_q;

   exec_decode u_dec (
      .word (insn),
      .dec  (dec)
   );

   exec_regfile #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (wr_en),
      .waddr  (dec.dst),
      .wdata  (result),
      .ra_a   (dec.src_a),
      .ra_b   (dec.src_b),
      .ra_dbg (dbg_sel),
      .rd_a   (val_a),
      .rd_b   (val_b),
      .rd_dbg (dbg_data)
   );

   exec_alu #(
      .DATA_W      (DATA_W),
      .LOG_SHIFTER (LOG_SHIFTER)
   ) u_alu (
      .op    (dec.op),
      .opa   (val_a),
      .opb   (val_b),
      .shamt (dec.shamt),
      .imm   (dec.imm),
      .res   (result)
   );

   assign wr_en = insn_en && dec.legal && (dec.dst != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         illegal_q <= 1'b0;
      else
         illegal_q <= insn_en && !dec.legal;
   end

   assign illegal = illegal_q;

endmodule

// File: rtl/exec_check.sv
module exec_check (
   input logic        clk,
   input logic        rst_n,
   input logic        insn_en,
   input logic [31:0] insn,
   input logic [4:0]  dbg_sel,
   input logic [31:0] dbg_data,
   input logic        illegal
);

   logic [5:0] c_op;
   logic [5:0] c_fn;
   logic       c_ok;

   assign c_op = insn[31:26];
   assign c_fn = insn[5:0];
   assign c_ok = (c_op == 6'd0 && (c_fn == 6'd0 || c_fn == 6'd32 || c_fn == 6'd35))
              || c_op == 6'd8 || c_op == 6'd10 || c_op == 6'd11
              || c_op == 6'd13 || c_op == 6'd15;

   always_comb begin
      if (rst_n && dbg_sel == 5'd0)
         assert_zero_reg_R10: assert (dbg_data == 32'd0);
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> !illegal);

   assert_illegal_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_en && !c_ok) |=> illegal);

   assert_no_spurious_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!insn_en || c_ok) |=> !illegal);

   assert_idle_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_en ##1 $stable(dbg_sel) |-> $stable(dbg_data));

   assert_illegal_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_en && !c_ok) ##1 $stable(dbg_sel) |-> $stable(dbg_data));

   assert_lui_place_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_en && c_op == 6'd15 && insn[20:16] != 5'd0 && insn[20:16] == dbg_sel)
      ##1 $stable(dbg_sel) |-> dbg_data == {$past(insn[15:0]), 16'h0000});

endmodule

bind int_exec_core exec_check u_exec_check (
   .clk      (clk),
   .rst_n    (rst_n),
   .insn_en  (insn_en),
   .insn     (insn),
   .dbg_sel  (dbg_sel),
   .dbg_data (dbg_data),
   .illegal  (illegal)
);

// File: tb/test_int_exec_core.sv
module test_int_exec_core;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_en = 1'b0;
   logic [31:0] insn = '0;
   logic [4:0]  dbg_sel = '0;
   logic [31:0] dbg_data;
   logic        illegal;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   int_exec_core i_int_exec_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .insn_en  (insn_en),
      .insn     (insn),
      .dbg_sel  (dbg_sel),
      .dbg_data (dbg_data),
      .illegal  (illegal)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] rtype(input logic [4:0] rs, rt, rd, sh, input logic [5:0] fn);
      return {6'd0, rs, rt, rd, sh, fn};
   endfunction

   function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rs, rt,
                                         input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // one enabled cycle; returns at the falling edge after the execute edge
   task automatic run(input logic [31:0] w);
      @(negedge clk);
      insn_en = 1'b1;
      insn    = w;
      @(posedge clk);
      @(negedge clk);
      insn_en = 1'b0;
      insn    = '0;
   endtask

   task automatic peek(input logic [4:0] r, output logic [31:0] v);
      dbg_sel = r;
      #1;
      v = dbg_data;
   endtask

   task automatic load(input logic [4:0] r, input logic [31:0] v);
      run(itype(6'd15, 5'd0, r, v[31:16]));
      run(itype(6'd13, r, r, v[15:0]));
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 illegal in reset", {31'd0, illegal}, 32'd0);
      for (int r = 0; r < 32; r++) begin
         peek(5'(r), v);
         check("R1 register after reset", v, 32'd0);
      end
   endtask

   task automatic t_add();
      logic [31:0] v;
      load(5'd9, 32'h0000_0010);
      load(5'd10, 32'h0000_0025);
      run(32'h012A_4020);
      peek(5'd8, v);  check("R2 add example word", v, 32'h0000_0035);
      check("R2 no flag", {31'd0, illegal}, 32'd0);
      run(rtype(5'd9, 5'd10, 5'd11, 5'd7, 6'd32));
      peek(5'd11, v); check("R4 shamt ignored by add", v, 32'h0000_0035);
      load(5'd9, 32'h7FFF_FFFF);
      load(5'd10, 32'h0000_0001);
      run(32'h012A_4020);
      peek(5'd8, v);  check("R2 add wraps without trap", v, 32'h8000_0000);
      check("R2 no flag on overflow", {31'd0, illegal}, 32'd0);
   endtask

   task automatic t_subu();
      logic [31:0] v;
      load(5'd1, 32'd5);
      load(5'd2, 32'd7);
      run(rtype(5'd1, 5'd2, 5'd12, 5'd0, 6'd35));
      peek(5'd12, v); check("R3 subu wraps", v, 32'hFFFF_FFFE);
      run(rtype(5'd2, 5'd1, 5'd12, 5'd0, 6'd35));
      peek(5'd12, v); check("R3 subu positive", v, 32'd2);
   endtask

   task automatic t_sll();
      logic [31:0] v;
      load(5'd2, 32'h0000_00F3);
      run(rtype(5'd0, 5'd2, 5'd13, 5'd4, 6'd0));
      peek(5'd13, v); check("R4 sll by 4", v, 32'h0000_0F30);
      load(5'd3, 32'd1);
      run(rtype(5'd0, 5'd3, 5'd13, 5'd31, 6'd0));
      peek(5'd13, v); check("R4 sll by 31", v, 32'h8000_0000);
      run(rtype(5'd0, 5'd2, 5'd13, 5'd0, 6'd0));
      peek(5'd13, v); check("R4 sll by 0", v, 32'h0000_00F3);
   endtask

   task automatic t_addi();
      logic [31:0] v;
      load(5'd22, 32'd100);
      run(32'h22D5_FFCE);
      peek(5'd21, v); check("R5 addi example word", v, 32'd50);
      run(itype(6'd8, 5'd22, 5'd21, 16'h7FFF));
      peek(5'd21, v); check("R5 addi max positive", v, 32'd100 + 32'h7FFF);
   endtask

   task automatic t_slt();
      logic [31:0] v;
      load(5'd5, 32'hFFFF_FFFF);
      run(itype(6'd10, 5'd5, 5'd6, 16'h0000));
      peek(5'd6, v); check("R6 slti -1 < 0", v, 32'd1);
      run(itype(6'd11, 5'd5, 5'd7, 16'h0000));
      peek(5'd7, v); check("R7 sltiu max < 0", v, 32'd0);
      load(5'd5, 32'd5);
      run(itype(6'd11, 5'd5, 5'd7, 16'hFFFF));
      peek(5'd7, v); check("R7 sltiu sign-extended imm", v, 32'd1);
      run(itype(6'd10, 5'd5, 5'd6, 16'hFFFF));
      peek(5'd6, v); check("R6 slti 5 < -1", v, 32'd0);
   endtask

   task automatic t_ori_lui();
      logic [31:0] v;
      load(5'd2, 32'h1234_0000);
      run(itype(6'd13, 5'd2, 5'd3, 16'h8001));
      peek(5'd3, v); check("R8 ori zero-extends", v, 32'h1234_8001);
      load(5'd4, 32'hFFFF_FFFF);
      run(itype(6'd15, 5'd0, 5'd4, 16'hABCD));
      peek(5'd4, v); check("R9 lui clears low half", v, 32'hABCD_0000);
   endtask

   task automatic t_zero();
      logic [31:0] v;
      run(itype(6'd8, 5'd0, 5'd0, 16'd5));
      peek(5'd0, v); check("R10 addi to r0 discarded", v, 32'd0);
      run(itype(6'd15, 5'd0, 5'd0, 16'hFFFF));
      peek(5'd0, v); check("R10 lui to r0 discarded", v, 32'd0);
   endtask

   task automatic t_illegal();
      logic [31:0] v;
      load(5'd14, 32'h0000_0055);
      run(itype(6'd35, 5'd0, 5'd14, 16'd1));
      check("R11 flag after bad opcode", {31'd0, illegal}, 32'd1);
      peek(5'd14, v); check("R11 bad opcode no write", v, 32'h0000_0055);
      @(negedge clk); #1;
      check("R11 flag lasts one cycle", {31'd0, illegal}, 32'd0);
      run(rtype(5'd0, 5'd0, 5'd14, 5'd0, 6'd33));
      check("R11 flag after bad function", {31'd0, illegal}, 32'd1);
      peek(5'd14, v); check("R11 bad function no write", v, 32'h0000_0055);
   endtask

   task automatic t_disabled();
      logic [31:0] v;
      @(negedge clk);
      insn = itype(6'd8, 5'd0, 5'd14, 16'd7);
      @(negedge clk);
      insn = itype(6'd63, 5'd0, 5'd14, 16'd7);
      @(negedge clk);
      insn = '0;
      #1;
      check("R12 no flag when disabled", {31'd0, illegal}, 32'd0);
      peek(5'd14, v); check("R12 no write when disabled", v, 32'h0000_0055);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_add();
      t_subu();
      t_sll();
      t_addi();
      t_slt();
      t_ori_lui();
      t_zero();
      t_illegal();
      t_disabled();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule